// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation Unit

This block places the secondary sample point used to check each transmitted bit in the fast data phase of a CAN FD frame. At high data rates the loop from the transmit pin, through the transceiver, back to the receive pin can take longer than the sample point. The receive line therefore has to be sampled at a point that is shifted by that loop delay. Every position is counted in clock periods, not time quanta.

Once per frame the unit measures the loop delay. A pulse on `tdc_arm` arms it. It then waits for a recessive-to-dominant edge on `tx_bit` and counts clocks until the matching edge shows up on `rx_bit`. The result is held until the next arm. For each data-phase bit, `bit_start` marks the start of the bit on the transmit side. The unit then computes a position and later raises `ssp_strobe` for exactly one cycle. In the same cycle it presents the captured receive value on `rx_sample`.

The position depends on the mode:
- **Disabled:** the nominal sample point.
- **Manual:** the configured delay plus the offset.
- **Automatic:** the measured delay plus the offset. A filter window can fall back to the nominal sample point.

The offset can be absolute, or relative to the nominal sample point, in which case it may be negative. A position can lie past the end of its own bit. Several per-bit countdown slots therefore run side by side.

The measurement controller is a four-state machine:
- **MS_IDLE:** after reset. It goes to MS_WAIT_TX on an arm pulse.
- **MS_WAIT_TX:** waits for the transmit edge. It goes to MS_COUNT on that edge, or directly to MS_HOLD if the receive edge falls in the same cycle.
- **MS_COUNT:** goes to MS_HOLD on the receive edge or on a timeout.
- **MS_HOLD:** holds the result. It goes to MS_WAIT_TX on the next arm pulse.

An arm pulse in any state restarts at MS_WAIT_TX.

Top module: `tdc_unit`

## Requirements
- R1: With both mode bits low, every data-phase bit yields one strobe at the nominal sample point SP = (1 + prop_seg + phase_seg1) × brp clock periods. The strobe is high in the cycle after clock edge SP, where edge 0 is the edge that samples `bit_start` high.
- R2: With only `mode_manual` set and `offset_rel` low, the strobe follows edge `tdcv_cfg` + `tdco_cfg`.
- R3: After a `tdc_arm` pulse, the first 1→0 change of `tx_bit` starts a count, and the first 1→0 change of `rx_bit` after it stops the count. `tdcv_meas` then equals the number of clock edges between the two. The value is held, unchanged by further line activity, until the next arm.
- R4: With only `mode_auto` set, the position is `tdcv_meas` + `tdco_cfg`, and `tdcv_cfg` has no effect.
- R5: In automatic mode only, if `tdcf_cfg` > `tdco_cfg` (both taken as unsigned) and the computed position is below `tdcf_cfg`, the strobe falls at SP instead. Manual mode never applies this filter.
- R6: With `offset_rel` high, `tdco_cfg` is a two's-complement value and the position is delay + SP + `tdco_cfg`. A result below 1 is raised to 1, and a result above 2^CNT_W−1 is lowered to that value.
- R7: If no receive edge arrives within one data bit time, (1 + prop_seg + phase_seg1 + phase_seg2) × brp edges after the transmit edge, then `tdcv_meas` becomes all ones and `delay_err` is set. A receive edge at exactly that count is still measured. The next arm clears `delay_err`.
- R8: With both mode bits set, `mode_err` is high and the strobe falls at SP.
- R9: Strobes of successive bits may overlap in time. A position beyond the bit length still yields one strobe per bit, with up to NSSP of them pending at once.
- R10: The strobe lasts one cycle. `rx_sample` takes the value `rx_bit` had just before the strobe edge and holds it until the next strobe.
- R11: After reset, `ssp_strobe`=0, `rx_sample`=1, `tdcv_meas`=0 and `delay_err`=0. A `bit_start` while `data_phase` is low produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit | input | 1 | Transmit line (1 = recessive) |
| rx_bit | input | 1 | Receive line (1 = recessive) |
| data_phase | input | 1 | High during the fast data phase; low flushes pending strobes |
| bit_start | input | 1 | One-cycle pulse at the start of each transmitted bit |
| tdc_arm | input | 1 | One-cycle pulse that starts a new delay measurement |
| mode_auto | input | 1 | Use the measured delay |
| mode_manual | input | 1 | Use the configured delay |
| offset_rel | input | 1 | Offset is signed and relative to the sample point |
| tdcv_cfg | input | CNT_W | Configured delay in clock periods |
| tdco_cfg | input | CNT_W | Offset in clock periods |
| tdcf_cfg | input | CNT_W | Filter window minimum position |
| brp | input | BRP_W | Data-phase prescaler (clocks per quantum) |
| prop_seg | input | SEG_W | Propagation segment in quanta |
| phase_seg1 | input | SEG_W | Phase segment 1 in quanta |
| phase_seg2 | input | SEG_W | Phase segment 2 in quanta |
| ssp_strobe | output | 1 | One-cycle secondary sample point strobe |
| rx_sample | output | 1 | Receive value captured at the strobe |
| tdcv_meas | output | CNT_W | Measured loop delay in clock periods |
| delay_err | output | 1 | Measurement timed out |
| mode_err | output | 1 | Both mode bits set |

## Verification
The assertions assume the following about the inputs:
- The bit timing stays unchanged while strobes are pending.
- A data bit lasts at least two clocks.
- `brp` is non-zero.

These three conditions are what make two strobes on consecutive cycles impossible. The stimulus keeps the bit-timing fields fixed for each vector, and it changes configuration only while `data_phase` is low. It uses bit times of 6 and 24 clocks. It raises `tdc_arm` only outside data-phase bits, and it returns both lines to recessive before the next measurement, so each arm sees a clean 1→0 transmit edge.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [1:0] {
        MS_IDLE,
        MS_WAIT_TX,
        MS_COUNT,
        MS_HOLD
    } meas_state_t;
endpackage

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas
    import tdc_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TQ_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic [TQ_W-1:0]  bit_tq,
    output logic [CNT_W-1:0] tdcv_meas,
    output logic             delay_err
);
    localparam int CMP_W = ((TQ_W > CNT_W) ? TQ_W : CNT_W) + 1;

    meas_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic tx_q, rx_q;
    logic tx_fall, rx_fall, timeout;

    assign tx_fall = tx_q & ~tx_bit;
    assign rx_fall = rx_q & ~rx_bit;
    assign timeout = (CMP_W'(cnt) >= CMP_W'(bit_tq)) || (cnt == '1);

    always_comb begin
        state_nx = state;
        unique case (state)
            MS_IDLE:    if (arm) state_nx = MS_WAIT_TX;
            MS_WAIT_TX: if (arm) state_nx = MS_WAIT_TX;
                        else if (tx_fall) state_nx = rx_fall ? MS_HOLD : MS_COUNT;
            MS_COUNT:   if (arm) state_nx = MS_WAIT_TX;
                        else if (rx_fall || timeout) state_nx = MS_HOLD;
            MS_HOLD:    if (arm) state_nx = MS_WAIT_TX;
            default:    state_nx = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= 1'b1;
            rx_q      <= 1'b1;
            cnt       <= '0;
            tdcv_meas <= '0;
            delay_err <= 1'b0;
        end else begin
            tx_q <= tx_bit;
            rx_q <= rx_bit;
            if (arm) begin
                cnt       <= '0;
                delay_err <= 1'b0;
            end else begin
                unique case (state)
                    MS_WAIT_TX: if (tx_fall) begin
                        if (rx_fall) tdcv_meas <= '0;
                        else         cnt <= CNT_W'(1);
                    end
                    MS_COUNT: begin
                        if (rx_fall) begin
                            tdcv_meas <= cnt;
                        end else if (timeout) begin
                            tdcv_meas <= '1;
                            delay_err <= 1'b1;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a held measurement stays put until re-armed
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_HOLD && !arm) |=> $stable(tdcv_meas));
    // R7: a timeout always reports the saturated value
    p_sat_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delay_err) |-> (tdcv_meas == '1));
    // R7: arming clears the error
    p_arm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !delay_err);
endmodule

// File: rtl/tdc_ssp_calc.sv
module tdc_ssp_calc #(
    parameter int CNT_W = 12,
    parameter int BRP_W = 6,
    parameter int SEG_W = 8,
    localparam int TQ_W = SEG_W + 2 + BRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_auto,
    input  logic             mode_manual,
    input  logic             offset_rel,
    input  logic [CNT_W-1:0] tdcv_cfg,
    input  logic [CNT_W-1:0] tdcv_meas,
    input  logic [CNT_W-1:0] tdco_cfg,
    input  logic [CNT_W-1:0] tdcf_cfg,
    input  logic [BRP_W-1:0] brp,
    input  logic [SEG_W-1:0] prop_seg,
    input  logic [SEG_W-1:0] phase_seg1,
    input  logic [SEG_W-1:0] phase_seg2,
    output logic [CNT_W-1:0] ssp_pos,
    output logic [TQ_W-1:0]  bit_tq,
    output logic             mode_err
);
    localparam int SW = ((TQ_W > CNT_W) ? TQ_W : CNT_W) + 3;
    localparam logic signed [SW-1:0] ONE_S   = SW'(1);
    localparam logic signed [SW-1:0] POS_MAX = SW'((1 << CNT_W) - 1);

    logic [TQ_W-1:0] sp_seg, bit_seg, sp_tq;
    logic signed [SW-1:0] base_s, off_s, sp_s, tdco_sx;
    logic [CNT_W-1:0] comp_pos, sp_pos;
    logic filt;

    function automatic logic [CNT_W-1:0] clamp_pos(input logic signed [SW-1:0] v);
        if (v < ONE_S)        return CNT_W'(1);
        else if (v > POS_MAX) return '1;
        else                  return v[CNT_W-1:0];
    endfunction

    assign sp_seg  = TQ_W'(prop_seg) + TQ_W'(phase_seg1) + TQ_W'(1);
    assign bit_seg = sp_seg + TQ_W'(phase_seg2);
    assign sp_tq   = sp_seg * TQ_W'(brp);
    assign bit_tq  = bit_seg * TQ_W'(brp);

    assign sp_s    = $signed(SW'(sp_tq));
    assign tdco_sx = $signed({{(SW-CNT_W){tdco_cfg[CNT_W-1]}}, tdco_cfg});
    assign base_s  = $signed(SW'(mode_auto ? tdcv_meas : tdcv_cfg));
    assign off_s   = offset_rel ? (sp_s + tdco_sx) : $signed(SW'(tdco_cfg));

    assign comp_pos = clamp_pos(base_s + off_s);
    assign sp_pos   = clamp_pos(sp_s);
    assign filt     = (tdcf_cfg > tdco_cfg) && (comp_pos < tdcf_cfg);
    assign mode_err = mode_auto & mode_manual;

    always_comb begin
        unique case ({mode_auto, mode_manual})
            2'b10:   ssp_pos = filt ? sp_pos : comp_pos;
            2'b01:   ssp_pos = comp_pos;
            default: ssp_pos = sp_pos;
        endcase
    end

    // R6: the position never drops to zero
    p_pos_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_pos != '0);
    // R8: an illegal mode falls back to the nominal point
    p_illegal_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (ssp_pos == sp_pos));
endmodule

// File: rtl/tdc_ssp_slots.sv
module tdc_ssp_slots #(
    parameter int CNT_W = 12,
    parameter int NSSP  = 4,
    localparam int PTR_W = (NSSP > 1) ? $clog2(NSSP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_pos,
    input  logic             flush,
    input  logic             rx_bit,
    output logic             ssp_strobe,
    output logic             rx_sample
);
    logic [NSSP-1:0] active, fire;
    logic [CNT_W-1:0] cnt [NSSP];
    logic [PTR_W-1:0] ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  ptr <= '0;
        else if (flush)                              ptr <= '0;
        else if (load && ptr == PTR_W'(NSSP - 1))    ptr <= '0;
        else if (load)                               ptr <= ptr + PTR_W'(1);
    end

    for (genvar i = 0; i < NSSP; i++) begin : g_slot
        assign fire[i] = active[i] && (cnt[i] == CNT_W'(1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active[i] <= 1'b0;
                cnt[i]    <= '0;
            end else if (flush) begin
                active[i] <= 1'b0;
            end else if (load && ptr == PTR_W'(i)) begin
                active[i] <= 1'b1;
                cnt[i]    <= load_pos;
            end else if (fire[i]) begin
                active[i] <= 1'b0;
            end else if (active[i]) begin
                cnt[i] <= cnt[i] - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ssp_strobe <= 1'b0;
            rx_sample  <= 1'b1;
        end else begin
            ssp_strobe <= |fire;
            if (|fire) rx_sample <= rx_bit;
        end
    end

    // R10: strobe is a single-cycle pulse
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_strobe |=> !ssp_strobe);
    // R11: a strobe needs a pending slot
    p_strobe_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_strobe |-> $past(|active));
    // R11: leaving the data phase drops all pending slots
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (active == '0));
endmodule

// File: rtl/tdc_unit.sv
module tdc_unit #(
    parameter int CNT_W = 12,
    parameter int BRP_W = 6,
    parameter int SEG_W = 8,
    parameter int NSSP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic             data_phase,
    input  logic             bit_start,
    input  logic             tdc_arm,
    input  logic             mode_auto,
    input  logic             mode_manual,
    input  logic             offset_rel,
    input  logic [CNT_W-1:0] tdcv_cfg,
    input  logic [CNT_W-1:0] tdco_cfg,
    input  logic [CNT_W-1:0] tdcf_cfg,
    input  logic [BRP_W-1:0] brp,
    input  logic [SEG_W-1:0] prop_seg,
    input  logic [SEG_W-1:0] phase_seg1,
    input  logic [SEG_W-1:0] phase_seg2,
    output logic             ssp_strobe,
    output logic             rx_sample,
    output logic [CNT_W-1:0] tdcv_meas,
    output logic             delay_err,
    output logic             mode_err
);
    localparam int TQ_W = SEG_W + 2 + BRP_W;

    logic [TQ_W-1:0]  bit_tq;
    logic [CNT_W-1:0] ssp_pos;

    tdc_delay_meas #(.CNT_W(CNT_W), .TQ_W(TQ_W)) meas_i (
        .clk(clk), .rst_n(rst_n), .arm(tdc_arm),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .bit_tq(bit_tq),
        .tdcv_meas(tdcv_meas), .delay_err(delay_err)
    );

    tdc_ssp_calc #(.CNT_W(CNT_W), .BRP_W(BRP_W), .SEG_W(SEG_W)) calc_i (
        .clk(clk), .rst_n(rst_n),
        .mode_auto(mode_auto), .mode_manual(mode_manual), .offset_rel(offset_rel),
        .tdcv_cfg(tdcv_cfg), .tdcv_meas(tdcv_meas), .tdco_cfg(tdco_cfg),
        .tdcf_cfg(tdcf_cfg), .brp(brp), .prop_seg(prop_seg),
        .phase_seg1(phase_seg1), .phase_seg2(phase_seg2),
        .ssp_pos(ssp_pos), .bit_tq(bit_tq), .mode_err(mode_err)
    );

    tdc_ssp_slots #(.CNT_W(CNT_W), .NSSP(NSSP)) slots_i (
        .clk(clk), .rst_n(rst_n),
        .load(bit_start & data_phase), .load_pos(ssp_pos),
        .flush(~data_phase), .rx_bit(rx_bit),
        .ssp_strobe(ssp_strobe), .rx_sample(rx_sample)
    );
endmodule

// File: tb/tdc_unit_tb.sv
module tdc_unit_tb_top;
    localparam int CNT_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit = 1'b1, rx_bit = 1'b1, data_phase = 1'b0, bit_start = 1'b0, tdc_arm = 1'b0;
    logic mode_auto = 1'b0, mode_manual = 1'b0, offset_rel = 1'b0;
    logic [11:0] tdcv_cfg = '0, tdco_cfg = '0, tdcf_cfg = '0;
    logic [5:0]  brp = 6'd2;
    logic [7:0]  prop_seg = 8'd3, phase_seg1 = 8'd4, phase_seg2 = 8'd4;
    logic ssp_strobe, rx_sample, delay_err, mode_err;
    logic [11:0] tdcv_meas;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tdc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .data_phase(data_phase), .bit_start(bit_start), .tdc_arm(tdc_arm),
        .mode_auto(mode_auto), .mode_manual(mode_manual), .offset_rel(offset_rel),
        .tdcv_cfg(tdcv_cfg), .tdco_cfg(tdco_cfg), .tdcf_cfg(tdcf_cfg),
        .brp(brp), .prop_seg(prop_seg), .phase_seg1(phase_seg1), .phase_seg2(phase_seg2),
        .ssp_strobe(ssp_strobe), .rx_sample(rx_sample), .tdcv_meas(tdcv_meas),
        .delay_err(delay_err), .mode_err(mode_err)
    );

    typedef struct packed {
        int am; int mm; int rel;
        int tdcv; int tdco; int tdcf;
        int brp; int prop; int ps1; int ps2;
        int dly; int exp_pos; int exp_merr;
    } vec_t;

    localparam int NV = 11;
    // Timing A: SP 16, bit 24. Timing B: SP 4, bit 6.
    localparam vec_t VECS [NV] = '{
        '{0,0,0,  5,   3,  0, 2,3,4,4, 5, 16,0},  // R1 disabled
        '{0,1,0,  7,  10,  0, 2,3,4,4, 5, 17,0},  // R2 manual absolute
        '{1,0,0, 50,  11,  0, 2,3,4,4, 9, 20,0},  // R4 auto, cfg delay ignored
        '{1,0,0,  0,   4, 20, 2,3,4,4, 9, 16,0},  // R5 filter falls back
        '{1,0,0,  0,   4,  4, 2,3,4,4, 9, 13,0},  // R5 window not above offset
        '{0,1,0,  5,   4, 30, 2,3,4,4, 9,  9,0},  // R5 no filter in manual
        '{0,1,1,  5,4093,  0, 2,3,4,4, 5, 18,0},  // R6 relative, -3
        '{1,0,1,  0,   2,  0, 2,3,4,4, 7, 25,0},  // R6 relative auto
        '{1,1,0,  3,   2,  0, 2,3,4,4, 5, 16,1},  // R8 both modes
        '{0,1,1,  1,4056,  0, 2,3,4,4, 5,  1,0},  // R6 clamp to 1
        '{1,0,0,  0,   2,  0, 1,2,1,2, 3,  5,0}   // R4 timing B
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int dly, input bit give_rx);
        @(negedge clk); tdc_arm = 1'b1;
        @(negedge clk); tdc_arm = 1'b0; tx_bit = 1'b0;
        if (give_rx) begin
            repeat (dly) @(negedge clk);
            rx_bit = 1'b0;
        end
        repeat (40) @(negedge clk);
        tx_bit = 1'b1; rx_bit = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_bit(output int pos);
        pos = -1;
        @(negedge clk); data_phase = 1'b1; bit_start = 1'b1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk); bit_start = 1'b0;
            if (ssp_strobe) begin pos = k; break; end
        end
        data_phase = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pos;
        int first, second, nstr, smp1, smp2;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 strobe", int'(ssp_strobe), 0);
        chk("R11 rx_sample", int'(rx_sample), 1);
        chk("R11 tdcv_meas", int'(tdcv_meas), 0);
        chk("R11 delay_err", int'(delay_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            mode_auto = 1'(VECS[v].am); mode_manual = 1'(VECS[v].mm); offset_rel = 1'(VECS[v].rel);
            tdcv_cfg = 12'(VECS[v].tdcv); tdco_cfg = 12'(VECS[v].tdco); tdcf_cfg = 12'(VECS[v].tdcf);
            brp = 6'(VECS[v].brp); prop_seg = 8'(VECS[v].prop);
            phase_seg1 = 8'(VECS[v].ps1); phase_seg2 = 8'(VECS[v].ps2);
            measure(VECS[v].dly, 1'b1);
            chk("R3 measured delay", int'(tdcv_meas), VECS[v].dly);
            chk("R8 mode_err", int'(mode_err), VECS[v].exp_merr);
            run_bit(pos);
            chk("R1/R2/R4/R5/R6 position", pos, VECS[v].exp_pos);
        end

        // R7 timeout and boundary, timing A (bit time 24)
        mode_auto = 1'b0; mode_manual = 1'b0; offset_rel = 1'b0;
        brp = 6'd2; prop_seg = 8'd3; phase_seg1 = 8'd4; phase_seg2 = 8'd4;
        measure(0, 1'b0);
        chk("R7 delay_err set", int'(delay_err), 1);
        chk("R7 saturated", int'(tdcv_meas), 4095);
        measure(24, 1'b1);
        chk("R7 err cleared by arm", int'(delay_err), 0);
        chk("R7 edge at bit time measured", int'(tdcv_meas), 24);

        // R3 hold: line activity without arm leaves the value
        @(negedge clk); tx_bit = 1'b0;
        repeat (3) @(negedge clk); rx_bit = 1'b0;
        repeat (5) @(negedge clk); tx_bit = 1'b1; rx_bit = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 held without arm", int'(tdcv_meas), 24);

        // R9/R10 overlap: position 30 with bit length 24
        mode_manual = 1'b1; tdcv_cfg = 12'd20; tdco_cfg = 12'd10; tdcf_cfg = 12'd0;
        data_phase = 1'b1;
        first = -1; second = -1; nstr = 0; smp1 = -1; smp2 = -1;
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            if (ssp_strobe) begin
                nstr++;
                if (first < 0) first = k - 1; else second = k - 1;
            end
            if (k == 31) smp1 = int'(rx_sample);
            if (k == 55) smp2 = int'(rx_sample);
            bit_start = (k == 0 || k == 24);
            rx_bit = (k >= 28 && k <= 32) ? 1'b0 : 1'b1;
        end
        data_phase = 1'b0; bit_start = 1'b0; rx_bit = 1'b1;
        chk("R9 strobe count", nstr, 2);
        chk("R9 first strobe edge", first, 30);
        chk("R9 second strobe edge", second, 54);
        chk("R10 sample at first strobe", smp1, 0);
        chk("R10 sample at second strobe", smp2, 1);

        // R11 no strobe outside the data phase
        nstr = 0;
        @(negedge clk); bit_start = 1'b1;
        @(negedge clk); bit_start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (ssp_strobe) nstr++;
        end
        chk("R11 idle bit_start", nstr, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule